// File: doc/BRIEF.md
# CAN Operating Mode Controller

This block owns the mode-selection part of a CAN controller's control register and decides which of four operating states the controller is in: sleep, reset, halt or operation. Software writes a two-bit mode request, a sleep request bit, a bus-off recovery code and a few configuration bits. The block resolves these writes into a current state. Software polls a reset-status bit to learn when entry into or exit from reset has finished.

The protocol engine runs only while the block reports operation. When the error logic signals bus-off entry and the recovery code selects automatic halt, the block leaves operation for halt without any software action. Mode changes that would cut a frame short (plain reset, halt, sleep) wait until the bus is idle. A forced reset and a return to operation do not wait. After a hardware reset the controller is in sleep.

Top module: `cmo_mode_ctrl`

## Requirements
- R1: After reset, op_mode reads 3 (sleep), rst_stat and engine_en are 0, and ctrl_rd reads 0x0500: sleep bit 10 is set and mode field [9:8] holds 01.
- R2: The mode request field ctrl_rd[9:8] reads back the last value written. Its codes are 00 operation, 01 reset, 10 halt and 11 forced reset. op_mode reports the state as 0 operation, 1 reset, 2 halt and 3 sleep.
- R3: A forced reset write (field 11) sets rst_stat after the second rising edge counted from the write, whether or not the bus is idle.
- R4: An operation write (field 00) clears rst_stat and sets engine_en after the second rising edge counted from the write.
- R5: While in operation with bus_idle low, a request for reset, halt or sleep is held pending and the state stays operation. The change happens on the first edge at which bus_idle is high.
- R6: The sleep bit (bit 10) is stored only when the same write puts 01 or 10 in the mode field. Otherwise it reads back 0 and the controller does not enter sleep.
- R7: The configuration bits [3:0] and the recovery code [12:11] take a write only while rst_stat is 1. In any other state they hold their value.
- R8: With recovery code 01, a bus_off_evt in operation moves the state to halt on the next edge and sets the mode field to 10. With any other code, bus_off_evt has no effect.
- R9: engine_en is 1 only in operation and rst_stat is 1 only in reset. The two are never high together.
- R10: When an automatic bus-off halt and a CPU mode write occur in the same cycle, the halt wins. The mode field reads 10.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous hardware reset |
| wr_en | input | 1 | Control register write strobe |
| wr_data | input | 16 | Control register write value |
| bus_idle | input | 1 | High when no frame is in progress on the bus |
| bus_off_evt | input | 1 | One-cycle pulse from the error logic on bus-off entry |
| op_mode | output | 2 | Current state: 0 operation, 1 reset, 2 halt, 3 sleep |
| rst_stat | output | 1 | Reset-status bit, 1 while in reset |
| engine_en | output | 1 | Enable for the protocol engine |
| ctrl_rd | output | 16 | Control register readback |

## Verification
The assertions check on every cycle that the configuration and recovery fields never change outside reset, that the sleep bit is only ever stored next to a reset or halt request, and that the status and enable outputs are never high together. They also check the fixed two-edge lag for forced reset and for a return to operation, the hold while the bus is busy, and the bus-off halt. Only the directed scenarios can show the exact start-up sequence from sleep, that a pending request completes once the bus goes idle, that a rejected sleep request leaves the controller in its current state, and that bus-off wins over a write made in the same cycle.

// File: rtl/cmo_pkg.sv
package cmo_pkg;

    // Current operating state, also the op_mode output encoding
    typedef enum logic [1:0] {
        ST_OPER  = 2'b00,
        ST_RESET = 2'b01,
        ST_HALT  = 2'b10,
        ST_SLEEP = 2'b11
    } op_state_e;

    // Mode request codes written into the control register
    localparam logic [1:0] REQ_OPER  = 2'b00;
    localparam logic [1:0] REQ_RESET = 2'b01;
    localparam logic [1:0] REQ_HALT  = 2'b10;
    localparam logic [1:0] REQ_FORCE = 2'b11;

    // Bus-off recovery code that selects automatic halt
    localparam logic [1:0] BO_AUTO_HALT = 2'b01;

    // Control register layout
    localparam int CFG_W     = 4;
    localparam int CFG_LSB   = 0;
    localparam int MODE_LSB  = 8;
    localparam int SLEEP_BIT = 10;
    localparam int BO_LSB    = 11;
    localparam int CTRL_MIN  = BO_LSB + 2;

    typedef struct packed {
        logic [1:0]       bo;
        logic             sleep;
        logic [1:0]       mode;
        logic [CFG_W-1:0] cfg;
    } ctrl_s;

endpackage

// File: rtl/cmo_ctrl_regs.sv
module cmo_ctrl_regs
    import cmo_pkg::*;
#(
    parameter int CTRL_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [CTRL_W-1:0] wr_data,
    input  logic              bus_off_evt,
    input  op_state_e         state,
    output ctrl_s             ctrl_q,
    output logic              bo_trig
);

    ctrl_s      ctrl_d;
    logic [1:0] wr_mode;
    logic       sleep_ok;

    always_comb begin
        wr_mode  = wr_data[MODE_LSB +: 2];
        sleep_ok = (wr_mode == REQ_RESET) || (wr_mode == REQ_HALT);
        bo_trig  = bus_off_evt && (state == ST_OPER) && (ctrl_q.bo == BO_AUTO_HALT);
        ctrl_d   = ctrl_q;
        if (wr_en) begin
            ctrl_d.mode  = wr_mode;
            ctrl_d.sleep = wr_data[SLEEP_BIT] && sleep_ok;
            if (state == ST_RESET) begin
                ctrl_d.cfg = wr_data[CFG_LSB +: CFG_W];
                ctrl_d.bo  = wr_data[BO_LSB +: 2];
            end
        end
        if (bo_trig) begin
            ctrl_d.mode  = REQ_HALT;
            ctrl_d.sleep = ctrl_q.sleep;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q.bo    <= 2'b00;
            ctrl_q.sleep <= 1'b1;
            ctrl_q.mode  <= REQ_RESET;
            ctrl_q.cfg   <= '0;
        end else begin
            ctrl_q <= ctrl_d;
        end
    end

endmodule

// File: rtl/cmo_mode_fsm.sv
module cmo_mode_fsm
    import cmo_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] mode_req,
    input  logic       sleep_req,
    input  logic       bus_idle,
    input  logic       bo_trig,
    output op_state_e  state_q
);

    op_state_e state_d;
    op_state_e target;
    logic      must_wait;

    always_comb begin
        if (sleep_req) begin
            target = ST_SLEEP;
        end else begin
            case (mode_req)
                REQ_OPER:  target = ST_OPER;
                REQ_HALT:  target = ST_HALT;
                default:   target = ST_RESET;
            endcase
        end
        // Leaving operation mid-frame is deferred, except for forced reset
        must_wait = (state_q == ST_OPER) && (target != ST_OPER) &&
                    (mode_req != REQ_FORCE) && !bus_idle;
        if (bo_trig) begin
            state_d = ST_HALT;
        end else if (must_wait) begin
            state_d = state_q;
        end else begin
            state_d = target;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_SLEEP;
        end else begin
            state_q <= state_d;
        end
    end

endmodule

// File: rtl/cmo_mode_ctrl.sv
module cmo_mode_ctrl
    import cmo_pkg::*;
#(
    parameter int CTRL_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [CTRL_W-1:0] wr_data,
    input  logic              bus_idle,
    input  logic              bus_off_evt,
    output logic [1:0]        op_mode,
    output logic              rst_stat,
    output logic              engine_en,
    output logic [CTRL_W-1:0] ctrl_rd
);

    ctrl_s     ctrl_q;
    op_state_e state_q;
    logic      bo_trig;

    cmo_ctrl_regs #(.CTRL_W(CTRL_W)) u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_en       (wr_en),
        .wr_data     (wr_data),
        .bus_off_evt (bus_off_evt),
        .state       (state_q),
        .ctrl_q      (ctrl_q),
        .bo_trig     (bo_trig)
    );

    cmo_mode_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .mode_req  (ctrl_q.mode),
        .sleep_req (ctrl_q.sleep),
        .bus_idle  (bus_idle),
        .bo_trig   (bo_trig),
        .state_q   (state_q)
    );

    always_comb begin
        op_mode   = state_q;
        rst_stat  = (state_q == ST_RESET);
        engine_en = (state_q == ST_OPER);
        ctrl_rd   = '0;
        ctrl_rd[CFG_LSB +: CFG_W] = ctrl_q.cfg;
        ctrl_rd[MODE_LSB +: 2]    = ctrl_q.mode;
        ctrl_rd[SLEEP_BIT]        = ctrl_q.sleep;
        ctrl_rd[BO_LSB +: 2]      = ctrl_q.bo;
    end

endmodule

// File: rtl/cmo_checker.sv
module cmo_checker
    import cmo_pkg::*;
#(
    parameter int CTRL_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic [CTRL_W-1:0] wr_data,
    input logic              bus_idle,
    input logic              bus_off_evt,
    input logic [1:0]        op_mode,
    input logic              rst_stat,
    input logic              engine_en,
    input logic [CTRL_W-1:0] ctrl_rd
);

    assert_force_lag_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_data[MODE_LSB +: 2] == REQ_FORCE && !bus_off_evt) ##1 !bus_off_evt
        |=> rst_stat);

    assert_oper_lag_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_data[MODE_LSB +: 2] == REQ_OPER && !bus_off_evt) ##1 !bus_off_evt
        |=> (engine_en && !rst_stat));

    assert_busy_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (op_mode == ST_OPER && !bus_idle && !bus_off_evt &&
         ctrl_rd[MODE_LSB +: 2] != REQ_FORCE)
        |=> op_mode == ST_OPER);

    assert_sleep_pair_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_rd[SLEEP_BIT] |-> (ctrl_rd[MODE_LSB +: 2] == REQ_RESET ||
                                ctrl_rd[MODE_LSB +: 2] == REQ_HALT));

    assert_cfg_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !rst_stat |=> ($stable(ctrl_rd[CFG_LSB +: CFG_W]) && $stable(ctrl_rd[BO_LSB +: 2])));

    assert_busoff_halt_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (op_mode == ST_OPER && bus_off_evt && ctrl_rd[BO_LSB +: 2] == BO_AUTO_HALT)
        |=> (op_mode == ST_HALT && ctrl_rd[MODE_LSB +: 2] == REQ_HALT && !engine_en));

    assert_excl_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({rst_stat, engine_en}));

endmodule

bind cmo_mode_ctrl cmo_checker #(.CTRL_W(CTRL_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_en       (wr_en),
    .wr_data     (wr_data),
    .bus_idle    (bus_idle),
    .bus_off_evt (bus_off_evt),
    .op_mode     (op_mode),
    .rst_stat    (rst_stat),
    .engine_en   (engine_en),
    .ctrl_rd     (ctrl_rd)
);

// File: tb/cmo_mode_ctrl_tb.sv
module cmo_mode_ctrl_tb;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [15:0] wr_data = '0;
    logic        bus_idle = 1'b1;
    logic        bus_off_evt = 1'b0;
    logic [1:0]  op_mode;
    logic        rst_stat;
    logic        engine_en;
    logic [15:0] ctrl_rd;

    int n_vec = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    cmo_mode_ctrl u_dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_en       (wr_en),
        .wr_data     (wr_data),
        .bus_idle    (bus_idle),
        .bus_off_evt (bus_off_evt),
        .op_mode     (op_mode),
        .rst_stat    (rst_stat),
        .engine_en   (engine_en),
        .ctrl_rd     (ctrl_rd)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [15:0] d);
        wr_en   = 1'b1;
        wr_data = d;
        @(negedge clk);
        wr_en   = 1'b0;
    endtask

    task automatic t_reset;
        chk("R1 op_mode", op_mode, 3);
        chk("R1 rst_stat", rst_stat, 0);
        chk("R1 engine_en", engine_en, 0);
        chk("R1 ctrl_rd", ctrl_rd, 16'h0500);
    endtask

    task automatic t_startup;
        wr(16'h030F);
        chk("R3 lag rst_stat", rst_stat, 0);
        chk("R7 cfg ignored in sleep", ctrl_rd, 16'h0300);
        tick(1);
        chk("R3 rst_stat", rst_stat, 1);
        chk("R2 op_mode reset", op_mode, 1);
        wr(16'h0B0D);
        chk("R7 cfg taken in reset", ctrl_rd, 16'h0B0D);
        wr(16'h0805);
        chk("R4 lag rst_stat", rst_stat, 1);
        tick(1);
        chk("R4 rst_stat", rst_stat, 0);
        chk("R4 engine_en", engine_en, 1);
        chk("R2 op_mode oper", op_mode, 0);
        chk("R2 ctrl_rd", ctrl_rd, 16'h0805);
    endtask

    task automatic t_cfg_hold;
        wr(16'h1002);
        chk("R7 cfg held in oper", ctrl_rd, 16'h0805);
        tick(1);
        chk("R7 state oper", op_mode, 0);
    endtask

    task automatic t_idle_wait;
        bus_idle = 1'b0;
        wr(16'h0905);
        tick(3);
        chk("R5 reset pending", op_mode, 0);
        chk("R2 field readback", ctrl_rd[9:8], 1);
        bus_idle = 1'b1;
        tick(1);
        chk("R5 reset after idle", rst_stat, 1);
        chk("R9 engine off in reset", engine_en, 0);
        wr(16'h0805);
        tick(1);
        chk("R4 back to oper", engine_en, 1);
        bus_idle = 1'b0;
        wr(16'h0A05);
        tick(3);
        chk("R5 halt pending", op_mode, 0);
        bus_idle = 1'b1;
        tick(1);
        chk("R2 halt state", op_mode, 2);
        chk("R9 halt flags", {rst_stat, engine_en}, 0);
        wr(16'h0805);
        tick(1);
        chk("R4 oper from halt", op_mode, 0);
        bus_idle = 1'b0;
        wr(16'h0B05);
        chk("R3 busy lag", rst_stat, 0);
        tick(1);
        chk("R3 forced while busy", rst_stat, 1);
        bus_idle = 1'b1;
    endtask

    task automatic t_sleep;
        wr(16'h0F05);
        chk("R6 sleep dropped with force", ctrl_rd, 16'h0B05);
        tick(1);
        chk("R6 stays reset", op_mode, 1);
        wr(16'h0D05);
        chk("R6 sleep stored", ctrl_rd, 16'h0D05);
        tick(1);
        chk("R6 sleep state", op_mode, 3);
        chk("R9 sleep flags", {rst_stat, engine_en}, 0);
        wr(16'h0405);
        chk("R6 sleep dropped with oper", ctrl_rd, 16'h0805);
        tick(1);
        chk("R6 left sleep", op_mode, 0);
    endtask

    task automatic t_busoff;
        bus_off_evt = 1'b1;
        tick(1);
        bus_off_evt = 1'b0;
        chk("R8 auto halt", op_mode, 2);
        chk("R8 field halt", ctrl_rd[9:8], 2);
        chk("R8 engine off", engine_en, 0);
        wr(16'h0305);
        tick(1);
        wr(16'h1305);
        chk("R7 code taken in reset", ctrl_rd, 16'h1305);
        wr(16'h1005);
        tick(1);
        chk("R4 oper again", op_mode, 0);
        bus_off_evt = 1'b1;
        tick(1);
        bus_off_evt = 1'b0;
        chk("R8 no auto halt", op_mode, 0);
        chk("R8 field kept", ctrl_rd, 16'h1005);
        wr(16'h0305);
        tick(1);
        wr(16'h0B05);
        wr(16'h0805);
        tick(1);
        chk("R4 oper with auto code", op_mode, 0);
        wr_en = 1'b1;
        wr_data = 16'h0B05;
        bus_off_evt = 1'b1;
        tick(1);
        wr_en = 1'b0;
        bus_off_evt = 1'b0;
        chk("R10 halt wins", op_mode, 2);
        chk("R10 field halt", ctrl_rd[9:8], 2);
        tick(1);
        chk("R10 still halt", op_mode, 2);
    endtask

    initial begin
        tick(3);
        rst_n = 1'b1;
        tick(1);
        t_reset();
        t_startup();
        t_cfg_hold();
        t_idle_wait();
        t_sleep();
        t_busoff();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 20000);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

endmodule